// File: doc/BRIEF.md
# Host Core Reservation Search

This block keeps one status entry per core: an action code and a data word. A requester gives its own core index, the action code to post and a data word. The block then looks for another core that is running in host context and has no action posted yet. The first such core it finds is claimed in the same clock in which it is tested. The claim writes the action code and data into that core's entry, so two requests can never take the same core. The block replies with the core index, or with an all-ones code when no core qualifies.

The search visits one entry per clock and goes round in a circle. It starts at the core just after the requester's own core, runs up to the highest core, wraps to core 0, and stops just before it would reach the requester again. A claimed core gives its entry back with a one-clock release strobe. Release is done in two steps: the data word is cleared on the strobe edge and the action code on the following edge. This way no searcher can see the entry as free while its data is still valid. Sending the inter-processor signal to the chosen core is left to the surrounding logic.

Top module: `core_claim_search`

## Requirements
- R1: After reset every entry holds action 0 and data 0, `rsp_valid` is low and `req_ready` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Candidates are examined one per clock, first from own+1 up to NUM_CORES-1. If the k-th examined candidate (counting from 1) is chosen, `rsp_valid` is high for exactly one cycle, starting k edges after the acceptance edge.
- R3: If the first pass finds nothing, the search wraps and examines core 0 up to own-1 in rising order.
- R4: A core qualifies only if its `in_host` bit is 1 and its action code is 0. A core whose action is being cleared on that same edge also qualifies. The first qualifying candidate in search order is chosen.
- R5: On the response edge, the chosen entry takes the requested action code and data word. These are seen in `slot_action[c*ACT_W +: ACT_W]` and `slot_data[c*DATA_W +: DATA_W]`.
- R6: When no candidate qualifies, `rsp_found` is 0 and `rsp_core` is all ones (CORE_W bits). The response comes NUM_CORES-1 edges after acceptance.
- R7: The requester's own core is never examined and never returned. This holds even when it is in host context and free.
- R8: A `rel_strobe[c]` pulse clears the data of entry c on its edge. The action code stays unchanged on that edge and is cleared on the next edge.
- R9: A release and a claim can meet on the same entry in the same clock: the release's action clear is due on the edge where the search examines that entry. In that case the release is applied first, the entry counts as free, and the claim's action and data end up in the entry.
- R10: `req_ready` is low from the cycle after acceptance until the response cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Search request |
| req_ready | output | 1 | Block idle, request can be taken |
| req_own | input | IDX_W | Requester's own core index |
| req_action | input | ACT_W | Nonzero action code to post |
| req_data | input | DATA_W | Data word to post with the action |
| rsp_valid | output | 1 | One-cycle search result strobe |
| rsp_found | output | 1 | A core was claimed |
| rsp_core | output | CORE_W | Claimed index, all ones when none |
| in_host | input | NUM_CORES | Per-core running-in-host flag |
| rel_strobe | input | NUM_CORES | Per-core release pulse |
| slot_action | output | NUM_CORES*ACT_W | Posted action code of each entry |
| slot_data | output | NUM_CORES*DATA_W | Posted data word of each entry |

## Verification
The properties assume the following about the inputs:
- `req_action` is nonzero and `req_own` is below NUM_CORES.
- `in_host` holds steady while a search runs.
- A release is pulsed only for an entry that holds a posted action.

The stimulus respects all of these. It changes `in_host` only while the block is idle. It uses nonzero action codes. It pulses a release only for a core the bench model records as claimed. The one deliberate overlap is the release of the entry that the search examines first, which is issued on the acceptance edge.

// File: rtl/ccs_pkg.sv
`timescale 1ns/1ps
package ccs_pkg;

    typedef enum logic [1:0] {
        SCAN_IDLE = 2'd0,
        SCAN_RUN  = 2'd1,
        SCAN_DONE = 2'd2
    } scan_st_e;

endpackage

// File: rtl/ccs_slot_table.sv
`timescale 1ns/1ps
module ccs_slot_table #(
    parameter int NUM_CORES = 8,
    parameter int ACT_W     = 3,
    parameter int DATA_W    = 8,
    parameter int IDX_W     = $clog2(NUM_CORES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          in_host,
    input  logic [NUM_CORES-1:0]          rel_strobe,
    input  logic                          claim_en,
    input  logic [IDX_W-1:0]              claim_idx,
    input  logic [ACT_W-1:0]              claim_act,
    input  logic [DATA_W-1:0]             claim_data,
    output logic [NUM_CORES-1:0]          slot_free,
    output logic [NUM_CORES*ACT_W-1:0]    slot_action,
    output logic [NUM_CORES*DATA_W-1:0]   slot_data
);

    typedef struct packed {
        logic [NUM_CORES-1:0][ACT_W-1:0]  act;
        logic [NUM_CORES-1:0][DATA_W-1:0] data;
        logic [NUM_CORES-1:0]             pend;   // action clear due next edge
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < NUM_CORES; i++) begin
            // second release step: action goes back to zero
            if (tbl_q.pend[i]) begin
                tbl_d.act[i]  = '0;
                tbl_d.pend[i] = 1'b0;
            end
            // first release step: data cleared, action held one more edge
            if (rel_strobe[i]) begin
                tbl_d.data[i] = '0;
                tbl_d.pend[i] = 1'b1;
            end
            // claim is applied after any release of the same entry
            if (claim_en && (claim_idx == IDX_W'(i))) begin
                tbl_d.act[i]  = claim_act;
                tbl_d.data[i] = claim_data;
                tbl_d.pend[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
        assign slot_free[g] = in_host[g] && ((tbl_q.act[g] == '0) || tbl_q.pend[g]);
        assign slot_action[g*ACT_W +: ACT_W]   = tbl_q.act[g];
        assign slot_data[g*DATA_W +: DATA_W]   = tbl_q.data[g];

        // R8: an action code only returns to zero after its data was zero
        a_r8_data_before_action: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(tbl_q.act[g]) != '0) && (tbl_q.act[g] == '0)) |-> ($past(tbl_q.data[g]) == '0));

        // R5: a claim on this entry lands on the following edge
        a_r5_claim_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_en && (claim_idx == IDX_W'(g))) |=>
                ((tbl_q.act[g] == $past(claim_act)) && (tbl_q.data[g] == $past(claim_data))));
    end

endmodule

// File: rtl/ccs_scan_engine.sv
`timescale 1ns/1ps
module ccs_scan_engine
    import ccs_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int ACT_W     = 3,
    parameter int DATA_W    = 8,
    parameter int IDX_W     = $clog2(NUM_CORES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [IDX_W-1:0]     req_own,
    input  logic [ACT_W-1:0]     req_action,
    input  logic [DATA_W-1:0]    req_data,
    output logic                 req_ready,
    input  logic [NUM_CORES-1:0] slot_free,
    output logic                 claim_en,
    output logic [IDX_W-1:0]     claim_idx,
    output logic [ACT_W-1:0]     claim_act,
    output logic [DATA_W-1:0]    claim_data,
    output logic                 rsp_valid,
    output logic                 rsp_found,
    output logic [IDX_W-1:0]     rsp_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(NUM_CORES - 1);
    localparam logic [IDX_W-1:0] STEP_COUNT = IDX_W'(NUM_CORES - 1);

    typedef struct packed {
        scan_st_e           st;
        logic [IDX_W-1:0]   own;
        logic [IDX_W-1:0]   cur;
        logic [IDX_W-1:0]   left;
        logic [IDX_W-1:0]   hit;
        logic               found;
        logic [ACT_W-1:0]   act;
        logic [DATA_W-1:0]  data;
    } eng_t;

    eng_t eng_d, eng_q;

    function automatic logic [IDX_W-1:0] circ_next(input logic [IDX_W-1:0] idx);
        return (idx == LAST_IDX) ? '0 : idx + 1'b1;
    endfunction

    always_comb begin
        eng_d    = eng_q;
        claim_en = 1'b0;
        unique case (eng_q.st)
            SCAN_IDLE: begin
                if (req_valid) begin
                    eng_d.st    = SCAN_RUN;
                    eng_d.own   = req_own;
                    eng_d.cur   = circ_next(req_own);
                    eng_d.left  = STEP_COUNT;
                    eng_d.found = 1'b0;
                    eng_d.act   = req_action;
                    eng_d.data  = req_data;
                end
            end
            SCAN_RUN: begin
                if (slot_free[eng_q.cur]) begin
                    claim_en    = 1'b1;      // test and claim in one step
                    eng_d.st    = SCAN_DONE;
                    eng_d.found = 1'b1;
                    eng_d.hit   = eng_q.cur;
                end else if (eng_q.left == IDX_W'(1)) begin
                    eng_d.st    = SCAN_DONE;
                    eng_d.found = 1'b0;
                end else begin
                    eng_d.cur   = circ_next(eng_q.cur);
                    eng_d.left  = eng_q.left - 1'b1;
                end
            end
            SCAN_DONE: eng_d.st = SCAN_IDLE;
            default:   eng_d.st = SCAN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign claim_idx  = eng_q.cur;
    assign claim_act  = eng_q.act;
    assign claim_data = eng_q.data;
    assign req_ready  = (eng_q.st == SCAN_IDLE);
    assign rsp_valid  = (eng_q.st == SCAN_DONE);
    assign rsp_found  = eng_q.found;
    assign rsp_idx    = eng_q.hit;

    // R7: the requester's own core is never the answer
    a_r7_never_own: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_found) |-> (rsp_idx != eng_q.own));

    // R2: one response per search, a single cycle wide
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: once a request is taken, no second one is offered next cycle
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/core_claim_search.sv
`timescale 1ns/1ps
module core_claim_search #(
    parameter int NUM_CORES = 8,
    parameter int ACT_W     = 3,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(NUM_CORES),
    localparam int CORE_W   = IDX_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [IDX_W-1:0]              req_own,
    input  logic [ACT_W-1:0]              req_action,
    input  logic [DATA_W-1:0]             req_data,
    output logic                          rsp_valid,
    output logic                          rsp_found,
    output logic [CORE_W-1:0]             rsp_core,
    input  logic [NUM_CORES-1:0]          in_host,
    input  logic [NUM_CORES-1:0]          rel_strobe,
    output logic [NUM_CORES*ACT_W-1:0]    slot_action,
    output logic [NUM_CORES*DATA_W-1:0]   slot_data
);

    logic [NUM_CORES-1:0] slot_free;
    logic                 claim_en;
    logic [IDX_W-1:0]     claim_idx;
    logic [ACT_W-1:0]     claim_act;
    logic [DATA_W-1:0]    claim_data;
    logic [IDX_W-1:0]     rsp_idx;

    ccs_scan_engine #(
        .NUM_CORES(NUM_CORES), .ACT_W(ACT_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_own    (req_own),
        .req_action (req_action),
        .req_data   (req_data),
        .req_ready  (req_ready),
        .slot_free  (slot_free),
        .claim_en   (claim_en),
        .claim_idx  (claim_idx),
        .claim_act  (claim_act),
        .claim_data (claim_data),
        .rsp_valid  (rsp_valid),
        .rsp_found  (rsp_found),
        .rsp_idx    (rsp_idx)
    );

    ccs_slot_table #(
        .NUM_CORES(NUM_CORES), .ACT_W(ACT_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_host     (in_host),
        .rel_strobe  (rel_strobe),
        .claim_en    (claim_en),
        .claim_idx   (claim_idx),
        .claim_act   (claim_act),
        .claim_data  (claim_data),
        .slot_free   (slot_free),
        .slot_action (slot_action),
        .slot_data   (slot_data)
    );

    assign rsp_core = rsp_found ? {1'b0, rsp_idx} : '1;

    // R4: the engine only claims a core that reports being in host context
    a_r4_claim_in_host: assert property (@(posedge clk) disable iff (!rst_n)
        claim_en |-> in_host[claim_idx]);

endmodule

// File: tb/core_claim_search_test.sv
`timescale 1ns/1ps
module core_claim_search_test;

    localparam int N  = 8;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int IW = $clog2(N);
    localparam int CW = IW + 1;
    localparam int NOT_FOUND = (1 << CW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [IW-1:0]  req_own = '0;
    logic [AW-1:0]  req_action = '0;
    logic [DW-1:0]  req_data = '0;
    logic           rsp_valid;
    logic           rsp_found;
    logic [CW-1:0]  rsp_core;
    logic [N-1:0]   in_host = '0;
    logic [N-1:0]   rel_strobe = '0;
    logic [N*AW-1:0] slot_action;
    logic [N*DW-1:0] slot_data;

    always #2.5 clk = ~clk;

    core_claim_search #(.NUM_CORES(N), .ACT_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_own(req_own), .req_action(req_action), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_core(rsp_core),
        .in_host(in_host), .rel_strobe(rel_strobe),
        .slot_action(slot_action), .slot_data(slot_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int sh_act[N];

    typedef struct {
        bit    found;
        int    core;
        string tag;
    } exp_t;
    exp_t exq[$];

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int act_of(input int c);
        return int'(slot_action[c*AW +: AW]);
    endfunction

    function automatic int data_of(input int c);
        return int'(slot_data[c*DW +: DW]);
    endfunction

    // scoreboard monitor
    exp_t mon_e;
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exq.size() == 0) begin
                check(1'b0, "R2 unexpected response", 1, 0);
            end else begin
                mon_e = exq.pop_front();
                check(rsp_found == mon_e.found, {mon_e.tag, " found flag"}, int'(rsp_found), int'(mon_e.found));
                check(int'(rsp_core) == mon_e.core, {mon_e.tag, " core index"}, int'(rsp_core), mon_e.core);
            end
        end
    end

    // driver: model the expected answer, push it, then issue the request
    task automatic do_search(input int own, input int act, input int dat,
                             input string tag, input int rel_core);
        exp_t e;
        int   pos = 0;
        int   exp_lat;
        int   lat;
        for (int k = 1; k < N; k++) begin
            int c = (own + k) % N;
            bit busy = (sh_act[c] != 0) && (c != rel_core);
            if (pos == 0 && in_host[c] && !busy) begin
                pos = k;
                e.core = c;
            end
        end
        e.found = (pos != 0);
        if (pos == 0) e.core = NOT_FOUND;
        e.tag = tag;
        exp_lat = (pos != 0) ? pos : N - 1;
        exq.push_back(e);

        while (!req_ready) @(negedge clk);
        req_own    = IW'(own);
        req_action = AW'(act);
        req_data   = DW'(dat);
        req_valid  = 1'b1;
        if (rel_core >= 0) rel_strobe[rel_core] = 1'b1;
        @(posedge clk); #1;
        req_valid  = 1'b0;
        rel_strobe = '0;
        check(req_ready == 1'b0, "R10 ready low while searching", int'(req_ready), 0);

        lat = 0;
        do begin
            @(posedge clk); lat++; #1;
        end while (!rsp_valid && lat < 16);
        check(lat == exp_lat, {tag, " response latency (R2)"}, lat, exp_lat);
        check(req_ready == 1'b0, "R10 ready low in response cycle", int'(req_ready), 0);

        if (rel_core >= 0) sh_act[rel_core] = 0;
        if (e.found) begin
            check(act_of(e.core) == act, "R5 claimed action written", act_of(e.core), act);
            check(data_of(e.core) == dat, "R5 claimed data written", data_of(e.core), dat);
            sh_act[e.core] = act;
        end
        @(negedge clk);
    endtask

    task automatic release_core(input int c);
        int old = sh_act[c];
        @(negedge clk);
        rel_strobe[c] = 1'b1;
        @(posedge clk); #1;
        rel_strobe = '0;
        check(data_of(c) == 0, "R8 data cleared on release edge", data_of(c), 0);
        check(act_of(c) == old, "R8 action held on release edge", act_of(c), old);
        @(posedge clk); #1;
        check(act_of(c) == 0, "R8 action cleared one edge later", act_of(c), 0);
        sh_act[c] = 0;
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) sh_act[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < N; i++) begin
            check(act_of(i) == 0, "R1 action after reset", act_of(i), 0);
            check(data_of(i) == 0, "R1 data after reset", data_of(i), 0);
        end
        check(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

        // R2: first pass picks own+1
        in_host = '1;
        do_search(3, 1, 8'h11, "R2 first pass", -1);
        // R4: next core skipped because it holds an action
        do_search(3, 2, 8'h22, "R4 busy entry skipped", -1);
        // R3: wrap from the highest core to core 0
        do_search(7, 3, 8'h33, "R3 wrap to zero", -1);
        // R3: long wrap, only core 2 in host
        in_host = 8'b0000_0100;
        do_search(5, 4, 8'h44, "R3 second pass", -1);
        // R7/R6: only own core in host gives not found
        in_host = 8'b0000_0010;
        do_search(1, 5, 8'h55, "R7 own core skipped", -1);
        // R6: no core in host
        in_host = '0;
        do_search(4, 6, 8'h66, "R6 none in host", -1);
        // R4: fill the table around own core 6
        in_host = '1;
        do_search(6, 1, 8'h71, "R4 fill a", -1);
        do_search(6, 2, 8'h72, "R4 fill b", -1);
        do_search(6, 3, 8'h73, "R4 fill c", -1);
        // R6/R7: all others busy, own core free but not chosen
        do_search(6, 4, 8'h74, "R6 all others busy", -1);
        check(act_of(6) == 0, "R7 own entry untouched", act_of(6), 0);
        // R8: release then re-claim
        release_core(4);
        do_search(6, 5, 8'h75, "R8 released core reclaimed", -1);
        // R9: release of the first candidate meets the claim
        in_host = 8'b0000_0100;
        do_search(1, 7, 8'h99, "R9 release before claim", 2);

        @(negedge clk);
        check(exq.size() == 0, "R2 all responses seen", exq.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule